// File: doc/BRIEF.md
# Raster interrupt latch controller

This block collects interrupt events for a video timing generator and turns them into one active-low interrupt request toward a processor. It watches a 9-bit raster line count supplied from outside and compares it with a programmable 9-bit target line. Three more event sources arrive as single-cycle pulses. Each source has a pending bit and an enable bit. A source event always sets its pending bit, whatever its enable bit says. The request line goes low while at least one pending source is also enabled.

Software uses a small register bus with four byte-wide registers. Two registers form the target line. One is the pending register: a read shows the pending bits and a summary bit, and a write acknowledges sources. The fourth is the enable register. A pending bit is cleared only by an acknowledge write or by hardware reset. Because of this, a stale event stays latched through any software re-initialisation that skips the acknowledge. If such a source is then enabled, the request is raised at once. Programming the target line to 511 stops raster events in practice, because the raster count never reaches that value.

Register map (`reg_addr`):
- 0: low eight bits of the target line.
- 1: control. Bit 7 is target-line bit 8. The other bits read 0.
- 2: pending register.
- 3: enable register.

The pending bit order is fixed: bit 0 is the raster source, and bits 1 to 3 are `src_evt[0]` to `src_evt[2]`. There is no stream data path, so every pin is a plain level or pulse and no back-pressure applies. The bus has no read strobe. `reg_rdata` is a combinational function of `reg_addr` and the stored state. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `raster_irq_ctrl`

## Requirements
- R1: A raster event sets pending bit 0 at the clock edge where it occurs. This happens even when enable bit 0 is 0.
- R2: The target line is {control bit 7, register 0 bits 7:0}. A raster event can only occur when `raster_line` equals this 9-bit value. Register 0 reads back its stored byte. Register 1 reads {target bit 8, 7'b0}.
- R3: A raster event occurs only on the first cycle in which `raster_line` equals the target line. An acknowledged bit stays clear while the two remain equal. A new event needs the two to differ and then match again.
- R4: With the target line at 511, raster counts from 0 to 311 set no pending bit.
- R5: A high cycle on `src_evt[k]` sets pending bit k+1. This does not depend on the enable register.
- R6: A write to register 2 clears every pending bit whose write-data bit in 3:0 is 1. Pending bits written with 0 are unchanged.
- R7: If an acknowledge of a bit and a new event for that bit happen in the same cycle, the bit is set afterwards.
- R8: `irq_n` is 0 exactly when some pending bit and its enable bit are both 1. A write to register 3 that enables a source which is already pending drives `irq_n` low right after that write's clock edge.
- R9: Register 2 reads as follows: bit 7 is 1 when (pending AND enable) is nonzero, bits 6:4 read 1, and bits 3:0 are the pending bits. It reads 0x70 when nothing is pending and 0x71 when only the raster bit is pending, in both cases with nothing enabled.
- R10: Register 3 reads {4'b1111, enable[3:0]}, which is 0xF0 when all sources are disabled.
- R11: Hardware reset clears the pending bits, the enable bits and the target line to 0. A pending bit survives writes to registers 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| raster_line | input | 9 | Current raster line from the external counter |
| src_evt | input | 3 | Event pulses for pending bits 3:1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check the following on every cycle:
- each event sets its pending bit, even when an acknowledge lands in the same cycle;
- an acknowledge without a coinciding event clears its bit;
- a pending bit holds its value when it is neither set nor acknowledged;
- a raster event never occurs on two cycles in a row;
- unmasking a pending source pulls `irq_n` low on the next cycle.

Only the bench's scenarios can show the following:
- the exact read-back bytes;
- the split of the 9-bit target line across two registers;
- the target of 511 staying silent over a whole raster sweep;
- the acknowledged raster bit staying clear while the line stays equal;
- stale pending bits surviving re-initialisation until a hardware reset.

// File: rtl/rli_pkg.sv
package rli_pkg;
  localparam int DATA_W = 8;
  localparam int NSRC   = 4;
  localparam int LINE_W = DATA_W + 1;

  typedef enum logic [1:0] {
    ADR_CMP_LO = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_LATCH  = 2'd2,
    ADR_MASK   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rli_regs.sv
module rli_regs
  import rli_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NS = NSRC,
  localparam int LW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  reg_addr_e     addr,
  input  logic [DW-1:0] wdata,
  output logic [LW-1:0] cmp_line,
  output logic [NS-1:0] mask
);
  logic [DW-1:0] cmp_lo_q;
  logic          cmp_hi_q;
  logic [NS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= 1'b0;
      mask_q   <= '0;
    end else if (wr) begin
      case (addr)
        ADR_CMP_LO: cmp_lo_q <= wdata;
        ADR_CTRL:   cmp_hi_q <= wdata[DW-1];
        ADR_MASK:   mask_q   <= wdata[NS-1:0];
        default:    ;
      endcase
    end
  end

  assign cmp_line = {cmp_hi_q, cmp_lo_q};
  assign mask     = mask_q;

  // R2: the high target bit moves only on a control-register write
  p_cmp_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADR_CTRL) |=> $stable(cmp_line[LW-1]));
endmodule

// File: rtl/rli_cmp.sv
module rli_cmp #(
  parameter int LW = rli_pkg::LINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] raster_line,
  input  logic [LW-1:0] cmp_line,
  output logic          hit
);
  logic match, match_q;

  assign match = (raster_line == cmp_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;
  end

  assign hit = match & ~match_q;

  // R3: a raster event cannot repeat on the following cycle
  p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/rli_latch.sv
module rli_latch #(
  parameter int NS = rli_pkg::NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set,
  input  logic [NS-1:0] ack,
  output logic [NS-1:0] pend
);
  for (genvar i = 0; i < NS; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (set[i]) q <= 1'b1;
      else if (ack[i]) q <= 1'b0;
    end
    assign pend[i] = q;

    // R7: an event beats a same-cycle acknowledge
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]);
    // R6: acknowledge without an event clears
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set[i]) |=> !pend[i]);
    // R11: no other path changes a pending bit
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack[i] && !set[i]) |=> $stable(pend[i]));
  end
endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl
  import rli_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NS = NSRC,
  localparam int LW   = DW + 1,
  localparam int PADL = DW - 1 - NS,
  localparam int PADM = DW - NS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] raster_line,
  input  logic [NS-2:0] src_evt,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  reg_addr_e     addr;
  logic [LW-1:0] cmp_line;
  logic [NS-1:0] mask, pend, set, ack;
  logic          hit, summary;

  assign addr = reg_addr_e'(reg_addr);

  rli_regs #(.DW(DW), .NS(NS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(addr), .wdata(reg_wdata),
    .cmp_line(cmp_line), .mask(mask)
  );

  rli_cmp #(.LW(LW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .raster_line(raster_line),
    .cmp_line(cmp_line), .hit(hit)
  );

  assign set = {src_evt, hit};
  assign ack = (reg_wr && addr == ADR_LATCH) ? reg_wdata[NS-1:0] : '0;

  rli_latch #(.NS(NS)) u_latch (
    .clk(clk), .rst_n(rst_n), .set(set), .ack(ack), .pend(pend)
  );

  assign summary = |(pend & mask);
  assign irq_n   = ~summary;

  always_comb begin
    case (addr)
      ADR_CMP_LO: reg_rdata = cmp_line[DW-1:0];
      ADR_CTRL:   reg_rdata = {cmp_line[LW-1], {(DW-1){1'b0}}};
      ADR_LATCH:  reg_rdata = {summary, {PADL{1'b1}}, pend};
      default:    reg_rdata = {{PADM{1'b1}}, mask};
    endcase
  end

  // R1: a raster event latches bit 0 whatever the mask holds
  p_raster_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend[0]);
  // R8: unmasking an already pending source raises the request at once
  p_unmask_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr == ADR_MASK && |(reg_wdata[NS-1:0] & pend) && !(|ack))
    |=> !irq_n);
endmodule

// File: tb/tb_raster_irq_ctrl.sv
module tb_raster_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] raster_line = 9'd100;
  logic [2:0] src_evt = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  raster_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .raster_line(raster_line), .src_evt(src_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic set_line(input logic [8:0] v);
    @(negedge clk);
    raster_line = v;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] e);
    @(negedge clk);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic t_reset;
    rd_chk("R11 reset pending", 2'd2, 8'h70);
    rd_chk("R10 reset enable", 2'd3, 8'hF0);
    rd_chk("R11 reset cmp lo", 2'd0, 8'h00);
    rd_chk("R11 reset cmp hi", 2'd1, 8'h00);
    chk("R8 reset irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_split_line;
    wr(2'd0, 8'h2C);
    wr(2'd1, 8'h80);
    rd_chk("R2 cmp lo readback", 2'd0, 8'h2C);
    rd_chk("R2 cmp hi readback", 2'd1, 8'h80);
    set_line(9'd44);
    rd_chk("R2 low byte alone no match", 2'd2, 8'h70);
    set_line(9'd300);
    rd_chk("R1 R9 raster pending unmasked", 2'd2, 8'h71);
    chk("R1 irq stays high masked", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_single_fire;
    wr(2'd2, 8'h01);
    repeat (3) @(negedge clk);
    rd_chk("R3 no refire while equal", 2'd2, 8'h70);
    set_line(9'd301);
    set_line(9'd300);
    rd_chk("R3 refire after leaving", 2'd2, 8'h71);
    wr(2'd2, 8'h01);
    rd_chk("R6 ack raster", 2'd2, 8'h70);
  endtask

  task automatic t_never_line;
    wr(2'd0, 8'hFF);
    for (int v = 0; v < 312; v++) begin
      @(negedge clk);
      raster_line = 9'(v);
    end
    @(negedge clk);
    rd_chk("R4 line 511 never latches", 2'd2, 8'h70);
  endtask

  task automatic t_ext;
    pulse(3'b101);
    rd_chk("R5 external events latched", 2'd2, 8'h7A);
    chk("R5 irq high masked", {7'd0, irq_n}, 8'h01);
    wr(2'd2, 8'h08);
    rd_chk("R6 partial ack", 2'd2, 8'h72);
    wr(2'd2, 8'h0F);
    rd_chk("R6 full ack", 2'd2, 8'h70);
  endtask

  task automatic t_unmask;
    wr(2'd3, 8'h0F);
    rd_chk("R10 enable readback", 2'd3, 8'hFF);
    rd_chk("R9 enabled nothing pending", 2'd2, 8'h70);
    chk("R8 irq high no pending", {7'd0, irq_n}, 8'h01);
    wr(2'd3, 8'h00);
    pulse(3'b001);
    chk("R8 irq high before unmask", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h02;
    @(posedge clk); #1;
    chk("R8 irq low right after unmask", {7'd0, irq_n}, 8'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R9 summary bit", 2'd2, 8'hF2);
    wr(2'd3, 8'h00);
    chk("R8 irq high after mask", {7'd0, irq_n}, 8'h01);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h80);
    rd_chk("R11 pending survives other writes", 2'd2, 8'h72);
    wr(2'd2, 8'h02);
    rd_chk("R6 ack bit1", 2'd2, 8'h70);
  endtask

  task automatic t_race;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02; src_evt = 3'b001;
    @(negedge clk);
    reg_wr = 1'b0; src_evt = '0;
    rd_chk("R7 event wins over ack", 2'd2, 8'h72);
  endtask

  task automatic t_hw_reset;
    wr(2'd3, 8'h02);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rd_chk("R11 reset clears pending", 2'd2, 8'h70);
    rd_chk("R11 reset clears enable", 2'd3, 8'hF0);
    rd_chk("R11 reset clears cmp hi", 2'd1, 8'h00);
    chk("R11 irq high after reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_line();
    t_single_fire();
    t_never_line();
    t_ext();
    t_unmask();
    t_race();
    t_hw_reset();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule